// File: doc/BRIEF.md
# Flash Command Sequencer

This block is the command front end of a NOR-style flash memory model. Each bus write delivers an address and a command byte. Most operations take two writes: an arming byte followed by a confirm byte. The block tracks these pairs and starts a modelled block erase or a one-time-programmable/lock register program. It supports suspending and resuming a running operation. It also loads a 16-bit read configuration word taken from the address of the confirm write. A wrong second byte raises a sticky sequence error in the status byte.

Each running operation is modelled as a busy countdown of fixed length, set by a parameter. While the countdown runs, the block takes only two commands: status-read selection and suspend. The block also drives a read-mode selector (array, status or configuration) that the read path of the flash model decodes.

The write port is a valid/ready stream. `cmd_ready` is always high, so the block never applies back-pressure. A beat is consumed on every clock edge where `cmd_valid` is high, and a beat the current state does not accept is dropped without side effects. Status, mode, configuration word and operation address are plain outputs.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the status byte is 0x80, the read mode is array (code 0), the configuration word is 0x0000 and the operation address is 0.
- R2: Writing 0x20 and then 0xD0 starts an erase at the edge that takes the 0xD0. The operation address takes that write's address, and the read mode becomes status (code 1). For the next ERASE_CYCLES cycles status bit 7 reads 0, and after that it reads 1 again.
- R3: Writing 0x20 and then any byte other than 0xD0 sets status bits 5 and 4, selects status read mode and starts no erase.
- R4: While an operation runs (status bit 7 = 0), every written byte other than 0x70 and 0xB0 is dropped. The read mode, configuration word and error bits stay unchanged. A 0x70 selects status mode.
- R5: 0xB0 written during a running operation suspends it at that edge. From the next cycle status bit 7 reads 1, together with bit 6 for an erase or bit 2 for a program. The remaining busy count is frozen, and this holds even when the 0xB0 arrives in the last busy cycle.
- R6: A suspended operation stays suspended whatever other bytes are written, including 0xB0 and 0x20. A 0xD0 resumes it, clears its suspend bit and runs the remaining count.
- R7: Writing 0x60 and then 0x03 loads address bits 15:0 of the 0x03 write into the configuration word and selects array read mode.
- R8: After 0x60, a second byte of 0x01, 0xD0 or 0x2F is accepted without error and leaves the read mode alone. Any other second byte sets status bits 5 and 4 and selects status mode.
- R9: Writing 0xC0 and then any byte starts a program operation. Status bit 7 reads 0 for PROG_CYCLES cycles, the operation address takes the second write's address, and the read mode becomes status.
- R10: Status bits 5 and 4 are sticky until a 0x50 is accepted while idle or suspended, which clears them.
- R11: While idle or suspended, 0xFF selects array mode (0), 0x70 status mode (1) and 0x90 configuration mode (2).
- R12: `cmd_ready` is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Write beat present |
| cmd_ready | output | 1 | Beat accepted (always 1) |
| cmd_addr | input | AW | Address of the write beat |
| cmd_data | input | 8 | Command byte of the write beat |
| status_reg | output | 8 | Status byte: bit 7 ready, 6 erase held, 5/4 sequence error, 2 program held |
| read_mode | output | 2 | 0 array, 1 status, 2 configuration |
| rcfg | output | 16 | Read configuration word |
| op_addr | output | AW | Address latched for the current erase or program |

## Verification
The hardest case to reach is a suspend that lands exactly on the final busy cycle. The operation must then freeze with one cycle left rather than finish, and on resume it must finish one cycle later. The bench arms a program, waits a counted PROG_CYCLES-1 idle cycles and then writes 0xB0, so the beat meets the last count. A cycle-level model runs alongside the design and checks the frozen count and the single resumed cycle. Dropped commands during a busy run and during suspension are also compared against the model, cycle by cycle, at the outputs.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam logic [7:0] OP_ERASE_ARM   = 8'h20;
  localparam logic [7:0] OP_CONFIRM     = 8'hD0;
  localparam logic [7:0] OP_SUSPEND     = 8'hB0;
  localparam logic [7:0] OP_CFG_ARM     = 8'h60;
  localparam logic [7:0] OP_LOCK        = 8'h01;
  localparam logic [7:0] OP_LOCKDOWN    = 8'h2F;
  localparam logic [7:0] OP_SET_RCFG    = 8'h03;
  localparam logic [7:0] OP_OTP_ARM     = 8'hC0;
  localparam logic [7:0] OP_CLR_ERR     = 8'h50;
  localparam logic [7:0] OP_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] OP_READ_STATUS = 8'h70;
  localparam logic [7:0] OP_READ_CFG    = 8'h90;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ERASE_ARM, ST_CFG_ARM, ST_OTP_ARM,
    ST_ERASING, ST_PROGRAMMING, ST_ERASE_HELD, ST_PROG_HELD
  } seq_state_t;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_STATUS = 2'd1,
    RM_CONFIG = 2'd2
  } rd_mode_t;
endpackage

// File: rtl/fcs_busy_timer.sv
module fcs_busy_timer #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec && cnt != '0) cnt <= cnt - W'(1);
  end

  assign last = (cnt == W'(1));
endmodule

// File: rtl/fcs_err_flag.sv
module fcs_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_err,
  input  logic clr_err,
  output logic err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err <= 1'b0;
    else if (set_err) err <= 1'b1;
    else if (clr_err) err <= 1'b0;
  end
endmodule

// File: rtl/fcs_read_mode.sv
module fcs_read_mode
  import flash_cmd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     to_array,
  input  logic     to_status,
  input  logic     to_config,
  output rd_mode_t mode
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mode <= RM_ARRAY;
    else if (to_status) mode <= RM_STATUS;
    else if (to_array)  mode <= RM_ARRAY;
    else if (to_config) mode <= RM_CONFIG;
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int AW           = 23,
  parameter int RCFG_W       = 16,
  parameter int ERASE_CYCLES = 40,
  parameter int PROG_CYCLES  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [AW-1:0]     cmd_addr,
  input  logic [7:0]        cmd_data,
  output logic [7:0]        status_reg,
  output logic [1:0]        read_mode,
  output logic [RCFG_W-1:0] rcfg,
  output logic [AW-1:0]     op_addr
);
  localparam int MAX_CYC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  seq_state_t       st, st_nxt;
  logic             acc;
  logic             tmr_load, tmr_dec, tmr_last;
  logic [CNT_W-1:0] tmr_val;
  logic             seq_err, err_clr, err;
  logic             go_array, go_status, go_cfg;
  logic             addr_cap, rcfg_cap;
  logic             plain_ok;
  rd_mode_t         mode;

  assign cmd_ready = 1'b1;
  assign acc       = cmd_valid & cmd_ready;

  // read-mode and clear commands honoured while idle or suspended
  assign plain_ok = (st == ST_IDLE) || (st == ST_ERASE_HELD) || (st == ST_PROG_HELD);

  always_comb begin
    st_nxt    = st;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    tmr_dec   = 1'b0;
    seq_err   = 1'b0;
    err_clr   = 1'b0;
    go_array  = 1'b0;
    go_status = 1'b0;
    go_cfg    = 1'b0;
    addr_cap  = 1'b0;
    rcfg_cap  = 1'b0;

    if (acc && plain_ok) begin
      case (cmd_data)
        OP_READ_ARRAY:  go_array  = 1'b1;
        OP_READ_STATUS: go_status = 1'b1;
        OP_READ_CFG:    go_cfg    = 1'b1;
        OP_CLR_ERR:     err_clr   = 1'b1;
        default: ;
      endcase
    end

    case (st)
      ST_IDLE: begin
        if (acc) begin
          case (cmd_data)
            OP_ERASE_ARM: st_nxt = ST_ERASE_ARM;
            OP_CFG_ARM:   st_nxt = ST_CFG_ARM;
            OP_OTP_ARM:   st_nxt = ST_OTP_ARM;
            default: ;
          endcase
        end
      end
      ST_ERASE_ARM: begin
        if (acc) begin
          go_status = 1'b1;
          if (cmd_data == OP_CONFIRM) begin
            st_nxt   = ST_ERASING;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(ERASE_CYCLES);
            addr_cap = 1'b1;
          end else begin
            st_nxt  = ST_IDLE;
            seq_err = 1'b1;
          end
        end
      end
      ST_CFG_ARM: begin
        if (acc) begin
          st_nxt = ST_IDLE;
          if (cmd_data == OP_SET_RCFG) begin
            rcfg_cap = 1'b1;
            go_array = 1'b1;
          end else if (cmd_data != OP_LOCK && cmd_data != OP_CONFIRM &&
                       cmd_data != OP_LOCKDOWN) begin
            seq_err   = 1'b1;
            go_status = 1'b1;
          end
        end
      end
      ST_OTP_ARM: begin
        if (acc) begin
          st_nxt    = ST_PROGRAMMING;
          tmr_load  = 1'b1;
          tmr_val   = CNT_W'(PROG_CYCLES);
          addr_cap  = 1'b1;
          go_status = 1'b1;
        end
      end
      ST_ERASING, ST_PROGRAMMING: begin
        if (acc && cmd_data == OP_READ_STATUS) go_status = 1'b1;
        if (acc && cmd_data == OP_SUSPEND) begin
          st_nxt = (st == ST_ERASING) ? ST_ERASE_HELD : ST_PROG_HELD;
        end else begin
          tmr_dec = 1'b1;
          if (tmr_last) st_nxt = ST_IDLE;
        end
      end
      ST_ERASE_HELD: if (acc && cmd_data == OP_CONFIRM) st_nxt = ST_ERASING;
      ST_PROG_HELD:  if (acc && cmd_data == OP_CONFIRM) st_nxt = ST_PROGRAMMING;
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      op_addr <= '0;
      rcfg    <= '0;
    end else begin
      st <= st_nxt;
      if (addr_cap) op_addr <= cmd_addr;
      if (rcfg_cap) rcfg    <= cmd_addr[RCFG_W-1:0];
    end
  end

  fcs_busy_timer #(.W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .dec      (tmr_dec),
    .last     (tmr_last)
  );

  fcs_err_flag u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_err (seq_err),
    .clr_err (err_clr),
    .err     (err)
  );

  fcs_read_mode u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .to_array  (go_array),
    .to_status (go_status),
    .to_config (go_cfg),
    .mode      (mode)
  );

  assign read_mode  = mode;
  assign status_reg = {(st != ST_ERASING) && (st != ST_PROGRAMMING),
                       st == ST_ERASE_HELD, err, err, 1'b0,
                       st == ST_PROG_HELD, 2'b00};
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
  parameter int RCFG_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [7:0]        cmd_data,
  input logic [7:0]        status_reg,
  input logic [1:0]        read_mode,
  input logic [RCFG_W-1:0] rcfg
);
  logic busy, held;
  assign busy = !status_reg[7];
  assign held = status_reg[6] | status_reg[2];

  assert_held_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({status_reg[6], status_reg[2]}) && (!held || status_reg[7]));

  assert_suspend_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy && cmd_data == 8'hB0) |=> (status_reg[7] && held));

  assert_busy_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy && cmd_data != 8'h70 && cmd_data != 8'hB0)
      |=> ($stable(rcfg) && $stable(read_mode) && $stable(status_reg[5:4])));

  assert_resume_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && held && cmd_data == 8'hD0) |=> !status_reg[7]);

  assert_sticky_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status_reg[5] && !(cmd_valid && cmd_data == 8'h50)) |=> status_reg[5]);

  assert_err_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    status_reg[5] == status_reg[4]);
endmodule

bind flash_cmd_seq fcs_checker #(.RCFG_W(RCFG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_data   (cmd_data),
  .status_reg (status_reg),
  .read_mode  (read_mode),
  .rcfg       (rcfg)
);

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb;
  localparam int AW = 23;
  localparam int EC = 40;
  localparam int PC = 12;

  localparam int S_IDLE = 0, S_EARM = 1, S_CARM = 2, S_OARM = 3,
                 S_ERUN = 4, S_PRUN = 5, S_EHLD = 6, S_PHLD = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0]    cmd_data = '0;
  logic [7:0]    status_reg;
  logic [1:0]    read_mode;
  logic [15:0]   rcfg;
  logic [AW-1:0] op_addr;

  always #5 clk = ~clk;

  flash_cmd_seq #(.AW(AW), .RCFG_W(16), .ERASE_CYCLES(EC), .PROG_CYCLES(PC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .status_reg(status_reg),
    .read_mode(read_mode), .rcfg(rcfg), .op_addr(op_addr)
  );

  // behavioural reference
  int            m_st = S_IDLE;
  int            m_left = 0;
  int            m_mode = 0;
  bit            m_err = 1'b0;
  logic [15:0]   m_rcfg = '0;
  logic [AW-1:0] m_op = '0;

  int    tests = 0;
  int    fails = 0;
  int    cyc = 0;
  bit    started = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R1";

  function automatic logic [7:0] exp_status();
    exp_status = {(m_st != S_ERUN && m_st != S_PRUN), (m_st == S_EHLD), m_err, m_err,
                  1'b0, (m_st == S_PHLD), 2'b00};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = S_IDLE; m_left = 0; m_mode = 0; m_err = 1'b0; m_rcfg = '0; m_op = '0;
    end else begin
      bit plain;
      plain = (m_st == S_IDLE || m_st == S_EHLD || m_st == S_PHLD);
      if (cmd_valid && plain) begin
        if (cmd_data == 8'hFF) m_mode = 0;
        if (cmd_data == 8'h70) m_mode = 1;
        if (cmd_data == 8'h90) m_mode = 2;
        if (cmd_data == 8'h50) m_err = 1'b0;
      end
      case (m_st)
        S_IDLE: if (cmd_valid) begin
          if (cmd_data == 8'h20) m_st = S_EARM;
          else if (cmd_data == 8'h60) m_st = S_CARM;
          else if (cmd_data == 8'hC0) m_st = S_OARM;
        end
        S_EARM: if (cmd_valid) begin
          m_mode = 1;
          if (cmd_data == 8'hD0) begin m_st = S_ERUN; m_left = EC; m_op = cmd_addr; end
          else begin m_st = S_IDLE; m_err = 1'b1; end
        end
        S_CARM: if (cmd_valid) begin
          m_st = S_IDLE;
          if (cmd_data == 8'h03) begin m_rcfg = cmd_addr[15:0]; m_mode = 0; end
          else if (!(cmd_data == 8'h01 || cmd_data == 8'hD0 || cmd_data == 8'h2F)) begin
            m_err = 1'b1; m_mode = 1;
          end
        end
        S_OARM: if (cmd_valid) begin
          m_st = S_PRUN; m_left = PC; m_op = cmd_addr; m_mode = 1;
        end
        S_ERUN, S_PRUN: begin
          if (cmd_valid && cmd_data == 8'h70) m_mode = 1;
          if (cmd_valid && cmd_data == 8'hB0) m_st = (m_st == S_ERUN) ? S_EHLD : S_PHLD;
          else begin
            m_left = m_left - 1;
            if (m_left == 0) m_st = S_IDLE;
          end
        end
        S_EHLD: if (cmd_valid && cmd_data == 8'hD0) m_st = S_ERUN;
        S_PHLD: if (cmd_valid && cmd_data == 8'hD0) m_st = S_PRUN;
        default: m_st = S_IDLE;
      endcase
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk("R12", "cmd_ready", 32'(cmd_ready), 32'd1);
      chk(cur_req, "status_reg", 32'(status_reg), 32'(exp_status()));
      chk(cur_req, "read_mode", 32'(read_mode), 32'(m_mode));
      chk(cur_req, "rcfg", 32'(rcfg), 32'(m_rcfg));
      chk(cur_req, "op_addr", 32'(op_addr), 32'(m_op));
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<=100000 cycles", cyc);
      finish_run();
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    cmd_valid = 1'b1; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_data = 8'h00;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    started = 1'b1;
    cur_req = "R1";
    rst_n = 1'b1;
    idle(2);

    cur_req = "R11";
    wr(23'h10, 8'h70); wr(23'h10, 8'h90); idle(1); wr(23'h10, 8'hFF); idle(1);

    cur_req = "R7";
    wr(23'h0, 8'h60); wr(23'h1ABCD, 8'h03); idle(1);
    wr(23'h0, 8'h90); wr(23'h0, 8'h60); wr(23'h12345, 8'h03); idle(1);

    cur_req = "R8";
    wr(23'h0, 8'h70);
    wr(23'h0, 8'h60); wr(23'h0, 8'h01);
    wr(23'h0, 8'h60); wr(23'h0, 8'hD0);
    wr(23'h0, 8'h60); wr(23'h0, 8'h2F); idle(1);
    wr(23'h0, 8'hFF); wr(23'h0, 8'h60); wr(23'h7, 8'h44); idle(1);

    cur_req = "R10";
    wr(23'h0, 8'hFF); wr(23'h0, 8'h33); wr(23'h0, 8'h90); idle(2);
    wr(23'h0, 8'h50); idle(1);

    cur_req = "R3";
    wr(23'h0, 8'hFF); wr(23'h0, 8'h20); wr(23'h400, 8'h20); idle(2);
    wr(23'h0, 8'h50); wr(23'h0, 8'hFF);

    cur_req = "R2";
    wr(23'h0, 8'h20); wr(23'h2A000, 8'hD0); idle(5);

    cur_req = "R4";
    wr(23'h0, 8'hFF); wr(23'h0, 8'h60); wr(23'h5555, 8'h03); wr(23'h0, 8'h20);
    wr(23'h0, 8'h50); wr(23'h0, 8'h90); wr(23'h0, 8'h70); idle(2);

    cur_req = "R5";
    wr(23'h0, 8'hB0); idle(4);

    cur_req = "R6";
    wr(23'h0, 8'hB0); wr(23'h0, 8'h20); wr(23'h0, 8'hC0); idle(20);
    wr(23'h0, 8'hFF); wr(23'h0, 8'hD0);

    cur_req = "R2";
    idle(EC + 5);

    cur_req = "R9";
    wr(23'h0, 8'hC0); wr(23'h3BEEF, 8'h5A); idle(PC + 3);

    cur_req = "R5";
    wr(23'h0, 8'hC0); wr(23'h11, 8'h00); idle(PC - 1);
    wr(23'h0, 8'hB0); idle(3);

    cur_req = "R6";
    wr(23'h0, 8'h90); wr(23'h0, 8'hD0); idle(4);

    cur_req = "R10";
    wr(23'h0, 8'h20); wr(23'h0, 8'h00); wr(23'h0, 8'hC0); wr(23'h0, 8'h01);
    wr(23'h0, 8'hB0); wr(23'h0, 8'h50); idle(2);
    wr(23'h0, 8'hD0); idle(PC + 2);

    finish_run();
  end
endmodule